// File: doc/BRIEF.md
# Address Decode Window Unit

This block sits on the CPU side of the address path and decides where a transaction goes. Five programmable windows each describe an address region aligned to 64 KB. A window has an enable flag, a target code, a base, a size mask and a remap base. For every request the unit reports whether some enabled window covers the 40-bit address, which window it was, the target code of that window, and the address after remapping. The upper bits of the address are replaced by the remap base, and the offset inside the window is kept.

Software programs the windows over a small register port with separate write and read addresses. The expected order for changing a live window is: turn it off, write base, remap and size, and then turn it on in the same control write that sets its target. Decoding is combinational from the stored configuration. A register write therefore changes the decode outcome from the cycle after the write edge.

Top module: `addr_win_decoder`

## Requirements
- R1: The register address is {window index, select}, with select as the two low bits: 0 control, 1 base, 2 size, 3 remap. Control holds the enable flag in bit 0 and the target code in bits 4:1. Base, size and remap occupy the low FIELD_W bits. A read returns the value last written to those bits, and every other bit reads as zero.
- R2: After synchronous reset, window 0 is enabled with target 0, base 0, remap 0 and size RST_SIZE (0x07FF by default, which is 128 MB). All other windows read as zero and are disabled.
- R3: A window covers the address when its enable flag is set and the address bits above bit GRAN_W, masked by the inverted size, equal the base masked the same way. Base and size are zero-extended. As a result, any address with a set bit above the field range misses every window.
- R4: A window with its enable flag clear never reports a hit, whatever its base, size or remap values are.
- R5: On a hit, dec_addr takes the remap bits wherever size is 0 and the request bits wherever size is 1. The low GRAN_W bits pass through unchanged. Read arithmetically, dec_addr equals (remap & ~size) plus the offset of the request inside the window.
- R6: When several enabled windows cover the address, the lowest-numbered one wins and supplies dec_win, dec_target and dec_addr.
- R7: When no window hits, dec_hit is 0, dec_win is 0, dec_target is 0, and dec_addr equals req_addr.
- R8: A register write has no effect on decoding in the cycle in which it is presented. It takes effect in the cycle after the clock edge that stores it.
- R9: Writes to a window index of NUM_WIN or above are ignored, and reads from such an index return zero.
- R10: The target code is passed through unchanged. The codes are 0 DRAM, 1 internal registers, 2 PCIe, 3 PCIe through the chip link, 4 boot ROM, 5 external link, 7 secure-processor RAM, and 8 coherency-fabric registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 5 | Write address {window, select} |
| reg_wr_data | input | 16 | Write data |
| reg_rd_addr | input | 5 | Read address {window, select} |
| reg_rd_data | output | 16 | Read data, combinational |
| req_addr | input | 40 | Transaction address |
| dec_hit | output | 1 | Some enabled window covers req_addr |
| dec_win | output | 3 | Winning window index |
| dec_target | output | 4 | Target code of the winning window |
| dec_addr | output | 40 | Translated address |

## Verification
The bench builds the unit with five windows and three reduced widths: a 16-bit address, a 16-byte granule and an 8-bit field (reset size 0x07). With these values the whole 65536-entry address space can be swept after each configuration. Each sweep reaches every window edge, every overlap and every address with bits set above the field range. The configurations cover the reset map, a disjoint map with a disabled window, and an overlapping map that exercises priority. Expected results come from range arithmetic on the base and size, not from bit masks.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;

    localparam int TGT_W = 4;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_BASE  = 2'd1,
        SEL_SIZE  = 2'd2,
        SEL_REMAP = 2'd3
    } reg_sel_e;

    typedef enum logic [TGT_W-1:0] {
        TGT_DRAM       = 4'd0,
        TGT_INT_REGS   = 4'd1,
        TGT_PCIE       = 4'd2,
        TGT_PCIE_LINK  = 4'd3,
        TGT_BOOT_ROM   = 4'd4,
        TGT_EXT_LINK   = 4'd5,
        TGT_SEC_RAM    = 4'd7,
        TGT_COH_REGS   = 4'd8
    } target_e;

    // register data must carry a full field and the control layout
    function automatic int data_width(int field_w);
        return (field_w > TGT_W + 1) ? field_w : TGT_W + 1;
    endfunction

endpackage

// File: rtl/addr_win_regs.sv
module addr_win_regs
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int FIELD_W = 16,
    parameter logic [FIELD_W-1:0] RST_SIZE = '1,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int RA_W   = IDX_W + SEL_W,
    localparam int DATA_W = data_width(FIELD_W)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [RA_W-1:0]                   wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [RA_W-1:0]                   rd_addr,
    output logic [DATA_W-1:0]                 rd_data,
    output logic [NUM_WIN-1:0]                win_en,
    output logic [NUM_WIN-1:0][TGT_W-1:0]     win_tgt,
    output logic [NUM_WIN-1:0][FIELD_W-1:0]   win_base,
    output logic [NUM_WIN-1:0][FIELD_W-1:0]   win_size,
    output logic [NUM_WIN-1:0][FIELD_W-1:0]   win_remap
);

    typedef struct packed {
        logic               en;
        logic [TGT_W-1:0]   tgt;
        logic [FIELD_W-1:0] base;
        logic [FIELD_W-1:0] size;
        logic [FIELD_W-1:0] remap;
    } win_cfg_t;

    win_cfg_t cfg_q [NUM_WIN];

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    reg_sel_e         wr_sel;
    reg_sel_e         rd_sel;

    assign wr_idx = wr_addr[RA_W-1:SEL_W];
    assign rd_idx = rd_addr[RA_W-1:SEL_W];
    assign wr_sel = reg_sel_e'(wr_addr[SEL_W-1:0]);
    assign rd_sel = reg_sel_e'(rd_addr[SEL_W-1:0]);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[w].en    <= (w == 0);
                cfg_q[w].tgt   <= '0;
                cfg_q[w].base  <= '0;
                cfg_q[w].size  <= (w == 0) ? RST_SIZE : '0;
                cfg_q[w].remap <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(w))) begin
                case (wr_sel)
                    SEL_CTRL: begin
                        cfg_q[w].en  <= wr_data[0];
                        cfg_q[w].tgt <= wr_data[TGT_W:1];
                    end
                    SEL_BASE:  cfg_q[w].base  <= wr_data[FIELD_W-1:0];
                    SEL_SIZE:  cfg_q[w].size  <= wr_data[FIELD_W-1:0];
                    default:   cfg_q[w].remap <= wr_data[FIELD_W-1:0];
                endcase
            end
        end

        assign win_en[w]    = cfg_q[w].en;
        assign win_tgt[w]   = cfg_q[w].tgt;
        assign win_base[w]  = cfg_q[w].base;
        assign win_size[w]  = cfg_q[w].size;
        assign win_remap[w] = cfg_q[w].remap;
    end

    // indices past the last window fall through to zero
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (rd_idx == IDX_W'(w)) begin
                case (rd_sel)
                    SEL_CTRL:  rd_data = DATA_W'({cfg_q[w].tgt, cfg_q[w].en});
                    SEL_BASE:  rd_data = DATA_W'(cfg_q[w].base);
                    SEL_SIZE:  rd_data = DATA_W'(cfg_q[w].size);
                    default:   rd_data = DATA_W'(cfg_q[w].remap);
                endcase
            end
        end
    end

endmodule

// File: rtl/addr_win_match.sv
module addr_win_match #(
    parameter int UPPER_W = 24,
    parameter int FIELD_W = 16
) (
    input  logic               en,
    input  logic [UPPER_W-1:0] addr_up,
    input  logic [FIELD_W-1:0] base,
    input  logic [FIELD_W-1:0] size,
    input  logic [FIELD_W-1:0] remap,
    output logic               hit,
    output logic [UPPER_W-1:0] xlat_up
);

    logic [UPPER_W-1:0] size_ext;
    logic [UPPER_W-1:0] base_ext;
    logic [UPPER_W-1:0] remap_ext;

    // zero extension makes bits above the field compare against 0
    assign size_ext  = UPPER_W'(size);
    assign base_ext  = UPPER_W'(base);
    assign remap_ext = UPPER_W'(remap);

    assign hit     = en && ((addr_up & ~size_ext) == (base_ext & ~size_ext));
    assign xlat_up = (remap_ext & ~size_ext) | (addr_up & size_ext);

endmodule

// File: rtl/addr_win_select.sv
module addr_win_select
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int UPPER_W = 24,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic [NUM_WIN-1:0]               hit_vec,
    input  logic [NUM_WIN-1:0][TGT_W-1:0]    tgt_vec,
    input  logic [NUM_WIN-1:0][UPPER_W-1:0]  xlat_vec,
    output logic                             any_hit,
    output logic [IDX_W-1:0]                 win_idx,
    output logic [TGT_W-1:0]                 tgt,
    output logic [UPPER_W-1:0]               xlat_up
);

    // scan downwards so the lowest hitting index is assigned last
    always_comb begin
        win_idx = '0;
        tgt     = '0;
        xlat_up = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                win_idx = IDX_W'(w);
                tgt     = tgt_vec[w];
                xlat_up = xlat_vec[w];
            end
        end
    end

    assign any_hit = |hit_vec;

endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int ADDR_W  = 40,
    parameter int GRAN_W  = 16,
    parameter int FIELD_W = 16,
    parameter logic [FIELD_W-1:0] RST_SIZE = 16'h07FF,
    localparam int IDX_W   = $clog2(NUM_WIN),
    localparam int RA_W    = IDX_W + SEL_W,
    localparam int DATA_W  = data_width(FIELD_W),
    localparam int UPPER_W = ADDR_W - GRAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [RA_W-1:0]   reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [RA_W-1:0]   reg_rd_addr,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              dec_hit,
    output logic [IDX_W-1:0]  dec_win,
    output logic [TGT_W-1:0]  dec_target,
    output logic [ADDR_W-1:0] dec_addr
);

    logic [NUM_WIN-1:0]               win_en;
    logic [NUM_WIN-1:0][TGT_W-1:0]    win_tgt;
    logic [NUM_WIN-1:0][FIELD_W-1:0]  win_base;
    logic [NUM_WIN-1:0][FIELD_W-1:0]  win_size;
    logic [NUM_WIN-1:0][FIELD_W-1:0]  win_remap;
    logic [NUM_WIN-1:0]               hit_vec;
    logic [NUM_WIN-1:0][UPPER_W-1:0]  xlat_vec;
    logic [UPPER_W-1:0]               sel_xlat;
    logic                             any_hit;

    addr_win_regs #(
        .NUM_WIN  (NUM_WIN),
        .FIELD_W  (FIELD_W),
        .RST_SIZE (RST_SIZE)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .wr_addr   (reg_wr_addr),
        .wr_data   (reg_wr_data),
        .rd_addr   (reg_rd_addr),
        .rd_data   (reg_rd_data),
        .win_en    (win_en),
        .win_tgt   (win_tgt),
        .win_base  (win_base),
        .win_size  (win_size),
        .win_remap (win_remap)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        addr_win_match #(
            .UPPER_W (UPPER_W),
            .FIELD_W (FIELD_W)
        ) u_match (
            .en      (win_en[w]),
            .addr_up (req_addr[ADDR_W-1:GRAN_W]),
            .base    (win_base[w]),
            .size    (win_size[w]),
            .remap   (win_remap[w]),
            .hit     (hit_vec[w]),
            .xlat_up (xlat_vec[w])
        );
    end

    addr_win_select #(
        .NUM_WIN (NUM_WIN),
        .UPPER_W (UPPER_W)
    ) u_select (
        .hit_vec  (hit_vec),
        .tgt_vec  (win_tgt),
        .xlat_vec (xlat_vec),
        .any_hit  (any_hit),
        .win_idx  (dec_win),
        .tgt      (dec_target),
        .xlat_up  (sel_xlat)
    );

    assign dec_hit  = any_hit;
    assign dec_addr = any_hit ? {sel_xlat, req_addr[GRAN_W-1:0]} : req_addr;

endmodule

// File: rtl/addr_win_checker.sv
module addr_win_checker
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int ADDR_W  = 40,
    parameter int GRAN_W  = 16,
    parameter int FIELD_W = 16,
    parameter int IDX_W   = 3,
    parameter int RA_W    = 5,
    parameter int DATA_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic [RA_W-1:0]   reg_wr_addr,
    input logic [DATA_W-1:0] reg_wr_data,
    input logic [RA_W-1:0]   reg_rd_addr,
    input logic [DATA_W-1:0] reg_rd_data,
    input logic [ADDR_W-1:0] req_addr,
    input logic [NUM_WIN-1:0] hit_vec,
    input logic              dec_hit,
    input logic [IDX_W-1:0]  dec_win,
    input logic [TGT_W-1:0]  dec_target,
    input logic [ADDR_W-1:0] dec_addr
);

    logic [IDX_W-1:0] wr_idx;
    logic             wr_live;
    logic [NUM_WIN-1:0] below_win;

    assign wr_idx  = reg_wr_addr[RA_W-1:SEL_W];
    assign wr_live = (int'(wr_idx) < NUM_WIN);

    always_comb begin
        below_win = '0;
        for (int w = 0; w < NUM_WIN; w++)
            if (w < int'(dec_win)) below_win[w] = 1'b1;
    end

    assert_miss_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !dec_hit |-> (dec_target == '0 && dec_win == '0 && dec_addr == req_addr));

    assert_no_stray_hit_R3: assert property (@(posedge clk) disable iff (rst)
        !dec_hit |-> (hit_vec == '0));

    assert_offset_kept_R5: assert property (@(posedge clk) disable iff (rst)
        dec_hit |-> (dec_addr[GRAN_W-1:0] == req_addr[GRAN_W-1:0]));

    assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (rst)
        dec_hit |-> (hit_vec[dec_win] && ((hit_vec & below_win) == '0)));

    assert_disable_stops_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && wr_live && reg_wr_addr[SEL_W-1:0] == SEL_CTRL && !reg_wr_data[0])
        |=> !(dec_hit && dec_win == $past(wr_idx)));

    assert_base_readback_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && wr_live && reg_wr_addr[SEL_W-1:0] == SEL_BASE && reg_rd_addr == reg_wr_addr)
        |=> (reg_rd_addr != $past(reg_rd_addr)) ||
            (reg_rd_data == DATA_W'($past(reg_wr_data[FIELD_W-1:0]))));

endmodule

bind addr_win_decoder addr_win_checker #(
    .NUM_WIN (NUM_WIN),
    .ADDR_W  (ADDR_W),
    .GRAN_W  (GRAN_W),
    .FIELD_W (FIELD_W),
    .IDX_W   (IDX_W),
    .RA_W    (RA_W),
    .DATA_W  (DATA_W)
) u_checker (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_wr_data (reg_wr_data),
    .reg_rd_addr (reg_rd_addr),
    .reg_rd_data (reg_rd_data),
    .req_addr    (req_addr),
    .hit_vec     (hit_vec),
    .dec_hit     (dec_hit),
    .dec_win     (dec_win),
    .dec_target  (dec_target),
    .dec_addr    (dec_addr)
);

// File: tb/test_addr_win_decoder.sv
module test_addr_win_decoder;
    import addr_win_pkg::*;

    localparam int NUM_WIN = 5;
    localparam int ADDR_W  = 16;
    localparam int GRAN_W  = 4;
    localparam int FIELD_W = 8;
    localparam int IDX_W   = 3;
    localparam int RA_W    = 5;
    localparam int DATA_W  = 8;
    localparam int SPAN    = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr_en = 1'b0;
    logic [RA_W-1:0]   reg_wr_addr = '0;
    logic [DATA_W-1:0] reg_wr_data = '0;
    logic [RA_W-1:0]   reg_rd_addr = '0;
    logic [DATA_W-1:0] reg_rd_data;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              dec_hit;
    logic [IDX_W-1:0]  dec_win;
    logic [TGT_W-1:0]  dec_target;
    logic [ADDR_W-1:0] dec_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench copy of the programmed map
    bit       m_en    [NUM_WIN];
    int       m_tgt   [NUM_WIN];
    int       m_base  [NUM_WIN];
    int       m_size  [NUM_WIN];
    int       m_remap [NUM_WIN];

    always #5 clk = ~clk;

    addr_win_decoder #(
        .NUM_WIN  (NUM_WIN),
        .ADDR_W   (ADDR_W),
        .GRAN_W   (GRAN_W),
        .FIELD_W  (FIELD_W),
        .RST_SIZE (8'h07)
    ) i_addr_win_decoder (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_addr (reg_rd_addr),
        .reg_rd_data (reg_rd_data),
        .req_addr    (req_addr),
        .dec_hit     (dec_hit),
        .dec_win     (dec_win),
        .dec_target  (dec_target),
        .dec_addr    (dec_addr)
    );

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(int win, int sel, int data);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_addr = RA_W'((win << 2) | sel);
        reg_wr_data = DATA_W'(data);
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic rd_check(string req, int win, int sel, int exp);
        reg_rd_addr = RA_W'((win << 2) | sel);
        #1;
        check(req, int'(reg_rd_data), exp);
    endtask

    // ordered reprogramming: off, base, remap, size, then target plus enable
    task automatic program_win(int w, bit en, int tgt, int base, int size, int remap);
        wr_reg(w, 0, 0);
        wr_reg(w, 1, base);
        wr_reg(w, 3, remap);
        wr_reg(w, 2, size);
        wr_reg(w, 0, (tgt << 1) | int'(en));
        m_en[w] = en; m_tgt[w] = tgt; m_base[w] = base;
        m_size[w] = size; m_remap[w] = remap;
    endtask

    // range arithmetic: window spans [lo, lo+size] in granule units
    task automatic sweep(string tag);
        for (int a = 0; a < SPAN; a++) begin
            int up, lo, ehit, ewin, etgt, eaddr;
            req_addr = ADDR_W'(a);
            #1;
            up = a >> GRAN_W;
            ehit = 0; ewin = 0; etgt = 0; eaddr = a;
            for (int w = 0; w < NUM_WIN; w++) begin
                lo = m_base[w] - (m_base[w] % (m_size[w] + 1));
                if (ehit == 0 && m_en[w] && up >= lo && up <= lo + m_size[w]) begin
                    ehit  = 1;
                    ewin  = w;
                    etgt  = m_tgt[w];
                    eaddr = (((m_remap[w] - (m_remap[w] % (m_size[w] + 1))) + (up - lo)) << GRAN_W)
                            + (a % (1 << GRAN_W));
                end
            end
            if (ehit != 0) begin
                check({tag, " R3 hit"},  int'(dec_hit), 1);
                check({tag, " R6 win"},  int'(dec_win), ewin);
                check({tag, " R10 target"}, int'(dec_target), etgt);
                check({tag, " R5 addr"}, int'(dec_addr), eaddr);
            end else begin
                check({tag, " R3 R4 miss"}, int'(dec_hit), 0);
                check({tag, " R7 win"},  int'(dec_win), 0);
                check({tag, " R7 target"}, int'(dec_target), 0);
                check({tag, " R7 addr"}, int'(dec_addr), a);
            end
        end
    endtask

    task automatic readback_all(string tag);
        for (int w = 0; w < 8; w++) begin
            bit live;
            live = (w < NUM_WIN);
            rd_check({tag, " R1 R9 ctrl"},  w, 0, live ? ((m_tgt[w] << 1) | int'(m_en[w])) : 0);
            rd_check({tag, " R1 R9 base"},  w, 1, live ? m_base[w]  : 0);
            rd_check({tag, " R1 R9 size"},  w, 2, live ? m_size[w]  : 0);
            rd_check({tag, " R1 R9 remap"}, w, 3, live ? m_remap[w] : 0);
        end
    endtask

    initial begin
        for (int w = 0; w < NUM_WIN; w++) begin
            m_en[w] = (w == 0); m_tgt[w] = 0; m_base[w] = 0;
            m_size[w] = (w == 0) ? 7 : 0; m_remap[w] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R2: reset map
        readback_all("reset R2");
        sweep("reset R2");

        // disjoint map, window 4 disabled
        program_win(0, 1'b1, int'(TGT_DRAM),    8'h00, 8'h3F, 8'h80);
        program_win(1, 1'b1, int'(TGT_PCIE),    8'h40, 8'h1F, 8'h40);
        program_win(2, 1'b1, int'(TGT_SEC_RAM), 8'hC0, 8'h0F, 8'h10);
        program_win(3, 1'b1, int'(TGT_COH_REGS),8'h60, 8'h00, 8'hFF);
        program_win(4, 1'b0, int'(TGT_BOOT_ROM),8'h80, 8'h7F, 8'h00);
        readback_all("disjoint");
        sweep("disjoint");

        // overlapping map, window 0 disabled with a live-looking range
        program_win(0, 1'b0, int'(TGT_INT_REGS),  8'h00, 8'hFF, 8'h00);
        program_win(1, 1'b1, int'(TGT_EXT_LINK),  8'h80, 8'h7F, 8'h00);
        program_win(2, 1'b1, int'(TGT_BOOT_ROM),  8'h80, 8'h3F, 8'h40);
        program_win(3, 1'b1, int'(TGT_INT_REGS),  8'h00, 8'hFF, 8'hAA);
        program_win(4, 1'b1, int'(TGT_PCIE_LINK), 8'h10, 8'h0F, 8'h20);
        sweep("overlap");

        // R9: writes beyond the last window leave everything untouched
        wr_reg(6, 0, 8'h11);
        wr_reg(5, 1, 8'h33);
        wr_reg(7, 2, 8'h44);
        readback_all("oob R9");
        sweep("oob R9");

        // R8: a disable write is not seen until after its edge
        @(negedge clk);
        req_addr    = 16'h0005;
        reg_wr_en   = 1'b1;
        reg_wr_addr = RA_W'(3 << 2);
        reg_wr_data = '0;
        #1;
        check("R8 before edge hit", int'(dec_hit), 1);
        check("R8 before edge win", int'(dec_win), 3);
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0;
        m_en[3] = 1'b0;
        check("R8 after edge hit", int'(dec_hit), 0);
        check("R8 after edge addr", int'(dec_addr), 16'h0005);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule